// File: doc/BRIEF.md
# Dual-channel ADC capture controller

This block runs two serial analog-to-digital converters on their own. For each conversion it sends the converter a one-cycle convert strobe. It then waits until the converter drops its busy line. Last, it clocks the 16-bit result out on a divided serial clock, most significant bit first. Each channel writes its results into its own capture buffer. The buffer word is 32 bits wide, and two consecutive samples share one word.

A processor uses a small word-addressed register port. One control word starts captures, selects the capture length per channel, and reports completion. Buffer reads go through the same port. Each channel either takes one sample into word 0, overwriting the last one, or takes a fixed-length burst of `BURST_LEN` samples. At the end of a capture the channel raises a sticky complete flag, and an interrupt follows it until software clears the flag.

Inside, each channel's serial receiver hands each sample to the packing writer over a valid/ready pair. The receiver holds a finished sample and starts no new conversion until the writer has taken it. The writer takes a sample in the cycle it is offered while its capture is active. The register port has no back-pressure: a read returns data with `reg_rvalid` exactly one cycle later.

Top module: `adc_pair_capture`

## Requirements
- R1: After reset `irq`, `adc_cnv`, `adc_sck` and `reg_rvalid` are 0, and the control word reads 0.
- R2: Each conversion has these phases in order:
  - `adc_cnv` is high for exactly one clock.
  - No serial clock edge occurs while busy is high.
  - Exactly 16 rising `adc_sck` edges follow, each level lasting `SCK_HALF` clocks.
  - `adc_sdo` is sampled at each rising edge, most significant bit first.
- R3: Control word (word address 0) has this layout:
  - Bits 1:0 hold the run mode of channel 0 and bits 3:2 that of channel 1.
  - Bit 8 is channel 0 complete and bit 9 is channel 1 complete.
  - Mode 0 means idle, 1 single capture, and 2 or 3 burst.
  - A nonzero mode written to an idle channel starts capture on the next cycle, and the mode reads back.
- R4: Single capture converts once and writes `{16'h0, sample}` to buffer word 0, overwriting any earlier content.
- R5: Burst capture converts `BURST_LEN` times into words 0 upward. The earlier sample of a pair goes in bits 15:0 and the later one in bits 31:16. For an odd count the final word carries zero in bits 31:16.
- R6: At the end of a capture the channel's complete bit becomes 1. `irq` is 1 exactly while either complete bit is 1.
- R7: In a control write, a 0 in a complete bit clears that bit and a 1 leaves it unchanged; software cannot set it.
- R8: While a channel is capturing, writes to its mode field are ignored: the mode reads back unchanged and no extra conversion occurs.
- R9: A read at a word address with the top bit set returns buffer data. The next bit down selects the channel, and the low bits select the word. Any other nonzero address reads 0. Data appears with `reg_rvalid` one cycle after `reg_rd`.
- R10: Both channels can capture at the same time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | clog2((BURST_LEN+1)/2)+2 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| adc_cnv | output | 2 | Convert strobe per channel |
| adc_sck | output | 2 | Serial clock per channel |
| adc_busy | input | 2 | Converter busy per channel |
| adc_sdo | input | 2 | Serial data from converter per channel |
| irq | output | 1 | Capture-complete interrupt |

## Verification
The bench builds the block with `BURST_LEN` = 5 and `SCK_HALF` = 2. With an odd burst length, the final word of every burst is half-filled, so the zero upper half is checked on each burst. A short burst also keeps the runs short enough to include concurrent and overlapping captures. With a half period of two clocks, the divider has to count past one, so a wrong terminal value shows up as a wrong edge count or a wrong sampled bit.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  localparam int NUM_CH = 2;
  localparam int SMP_W  = 16;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_CNV   = 2'd1,
    RX_WAIT  = 2'd2,
    RX_SHIFT = 2'd3
  } rx_state_e;

  function automatic int buf_words(input int burst);
    return (burst + 1) / 2;
  endfunction

  function automatic int buf_aw(input int burst);
    return (buf_words(burst) > 1) ? $clog2(buf_words(burst)) : 1;
  endfunction

  function automatic int addr_bits(input int burst);
    return buf_aw(burst) + 2;
  endfunction
endpackage

// File: rtl/adc_serial_rx.sv
module adc_serial_rx
  import adc_cap_pkg::*;
#(
  parameter int SCK_HALF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             busy_i,
  input  logic             sdo_i,
  output logic             cnv_o,
  output logic             sck_o,
  output logic             smp_valid_o,
  input  logic             smp_ready_i,
  output logic [SMP_W-1:0] smp_data_o,
  output logic             idle_o
);
  localparam int DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam int BIT_W = $clog2(SMP_W + 1);

  rx_state_e        st_q;
  logic [DIV_W-1:0] div_q;
  logic [BIT_W-1:0] bits_q;
  logic [SMP_W-1:0] sh_q;
  logic             sck_q;
  logic             vld_q;
  logic             tick;

  assign tick = (div_q == DIV_W'(SCK_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      div_q  <= '0;
      bits_q <= '0;
      sh_q   <= '0;
      sck_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      if (vld_q && smp_ready_i) vld_q <= 1'b0;
      case (st_q)
        RX_IDLE:  if (start_i && !vld_q) st_q <= RX_CNV;
        RX_CNV:   st_q <= RX_WAIT;
        RX_WAIT: begin
          if (!busy_i) begin
            st_q   <= RX_SHIFT;
            div_q  <= '0;
            bits_q <= '0;
          end
        end
        RX_SHIFT: begin
          if (tick) begin
            div_q <= '0;
            if (!sck_q) begin
              sck_q  <= 1'b1;
              sh_q   <= {sh_q[SMP_W-2:0], sdo_i};
              bits_q <= bits_q + 1'b1;
            end else begin
              sck_q <= 1'b0;
              if (bits_q == BIT_W'(SMP_W)) begin
                st_q  <= RX_IDLE;
                vld_q <= 1'b1;
              end
            end
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign cnv_o       = (st_q == RX_CNV);
  assign sck_o       = sck_q;
  assign smp_valid_o = vld_q;
  assign smp_data_o  = sh_q;
  assign idle_o      = (st_q == RX_IDLE) && !vld_q;

  // R2: the convert strobe lasts a single clock
  p_cnv_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_o |=> !cnv_o);

  // R2: no serial clock rising edge while the converter reports busy
  p_no_sck_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_o) |-> !busy_i);
endmodule

// File: rtl/adc_sample_packer.sv
module adc_sample_packer
  import adc_cap_pkg::*;
#(
  parameter int BURST_LEN = 1000,
  parameter int AW        = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              burst_i,
  input  logic              rx_idle_i,
  input  logic              smp_valid_i,
  output logic              smp_ready_o,
  input  logic [SMP_W-1:0]  smp_data_i,
  output logic              conv_req_o,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              finish_o,
  output logic              active_o
);
  localparam int CNT_W = $clog2(BURST_LEN + 1);
  localparam int WORDS = buf_words(BURST_LEN);

  logic             active_q, burst_q, pend_q, half_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] total;
  logic [AW-1:0]    widx_q;
  logic [SMP_W-1:0] lo_q;
  logic             take, last;

  assign total       = burst_q ? CNT_W'(BURST_LEN) : CNT_W'(1);
  assign last        = (cnt_q == total - 1'b1);
  assign smp_ready_o = active_q;
  assign take        = smp_valid_i && active_q;
  assign conv_req_o  = active_q && !pend_q && rx_idle_i;
  assign active_o    = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      burst_q   <= 1'b0;
      pend_q    <= 1'b0;
      half_q    <= 1'b0;
      cnt_q     <= '0;
      widx_q    <= '0;
      lo_q      <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      finish_o  <= 1'b0;
    end else begin
      wr_en_o  <= 1'b0;
      finish_o <= 1'b0;
      if (start_i && !active_q) begin
        active_q <= 1'b1;
        burst_q  <= burst_i;
        pend_q   <= 1'b0;
        half_q   <= 1'b0;
        cnt_q    <= '0;
        widx_q   <= '0;
      end else begin
        if (conv_req_o) pend_q <= 1'b1;
        if (take) begin
          pend_q <= 1'b0;
          cnt_q  <= cnt_q + 1'b1;
          if (!half_q) begin
            if (last) begin
              wr_en_o   <= 1'b1;
              wr_addr_o <= widx_q;
              wr_data_o <= {{(WORD_W-SMP_W){1'b0}}, smp_data_i};
            end else begin
              lo_q   <= smp_data_i;
              half_q <= 1'b1;
            end
          end else begin
            wr_en_o   <= 1'b1;
            wr_addr_o <= widx_q;
            wr_data_o <= {smp_data_i, lo_q};
            widx_q    <= widx_q + 1'b1;
            half_q    <= 1'b0;
          end
          if (last) begin
            active_q <= 1'b0;
            finish_o <= 1'b1;
          end
        end
      end
    end
  end

  // R4: a single capture only ever writes word 0
  p_single_word0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && !burst_q) |-> (wr_addr_o == '0));

  // R5: burst writes stay inside the buffer
  p_addr_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (int'(wr_addr_o) < WORDS));
endmodule

// File: rtl/adc_word_ram.sv
module adc_word_ram
  import adc_cap_pkg::*;
#(
  parameter int DEPTH = 500,
  parameter int AW    = 9
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_addr) < DEPTH)) mem_q[wr_addr] <= wr_data;
    if (int'(rd_addr) < DEPTH) rd_data <= mem_q[rd_addr];
    else                       rd_data <= '0;
  end
endmodule

// File: rtl/adc_pair_capture.sv
module adc_pair_capture
  import adc_cap_pkg::*;
#(
  parameter int BURST_LEN = 1000,
  parameter int SCK_HALF  = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              reg_wr,
  input  logic                              reg_rd,
  input  logic [addr_bits(BURST_LEN)-1:0]   reg_addr,
  input  logic [31:0]                       reg_wdata,
  output logic [31:0]                       reg_rdata,
  output logic                              reg_rvalid,
  output logic [1:0]                        adc_cnv,
  output logic [1:0]                        adc_sck,
  input  logic [1:0]                        adc_busy,
  input  logic [1:0]                        adc_sdo,
  output logic                              irq
);
  localparam int WORDS  = buf_words(BURST_LEN);
  localparam int BUF_AW = buf_aw(BURST_LEN);
  localparam int ADDR_W = addr_bits(BURST_LEN);

  logic              ctrl_wr, ctrl_sel, buf_sel;
  logic [NUM_CH-1:0] done_q, start_q, active, finish;
  logic [1:0]        mode_q [NUM_CH];
  logic [WORD_W-1:0] ram_q  [NUM_CH];
  logic [31:0]       ctrl_word, ctrl_snap_q;
  logic              r_buf_q, r_ch_q, r_ctrl_q;

  wire unused_wdata_bits = ^{reg_wdata[31:10], reg_wdata[7:4]};

  assign ctrl_wr  = reg_wr && (reg_addr == '0);
  assign ctrl_sel = (reg_addr == '0);
  assign buf_sel  = reg_addr[ADDR_W-1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic             req, rx_idle, s_valid, s_ready;
    logic [SMP_W-1:0] s_data;
    logic             w_en;
    logic [BUF_AW-1:0] w_addr;
    logic [WORD_W-1:0] w_data;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q[c]  <= 2'd0;
        start_q[c] <= 1'b0;
        done_q[c]  <= 1'b0;
      end else begin
        start_q[c] <= 1'b0;
        if (ctrl_wr && !active[c] && !start_q[c]) begin
          mode_q[c]  <= reg_wdata[2*c+1 -: 2];
          start_q[c] <= (reg_wdata[2*c+1 -: 2] != 2'd0);
        end
        if (finish[c])                           done_q[c] <= 1'b1;
        else if (ctrl_wr && !reg_wdata[8 + c])   done_q[c] <= 1'b0;
      end
    end

    adc_serial_rx #(.SCK_HALF(SCK_HALF)) i_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (req),
      .busy_i      (adc_busy[c]),
      .sdo_i       (adc_sdo[c]),
      .cnv_o       (adc_cnv[c]),
      .sck_o       (adc_sck[c]),
      .smp_valid_o (s_valid),
      .smp_ready_i (s_ready),
      .smp_data_o  (s_data),
      .idle_o      (rx_idle)
    );

    adc_sample_packer #(.BURST_LEN(BURST_LEN), .AW(BUF_AW)) i_pack (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_q[c]),
      .burst_i     (mode_q[c][1]),
      .rx_idle_i   (rx_idle),
      .smp_valid_i (s_valid),
      .smp_ready_o (s_ready),
      .smp_data_i  (s_data),
      .conv_req_o  (req),
      .wr_en_o     (w_en),
      .wr_addr_o   (w_addr),
      .wr_data_o   (w_data),
      .finish_o    (finish[c]),
      .active_o    (active[c])
    );

    adc_word_ram #(.DEPTH(WORDS), .AW(BUF_AW)) i_ram (
      .clk     (clk),
      .wr_en   (w_en),
      .wr_addr (w_addr),
      .wr_data (w_data),
      .rd_addr (reg_addr[BUF_AW-1:0]),
      .rd_data (ram_q[c])
    );

    // R8: the mode field cannot change while the channel captures
    p_mode_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      active[c] |=> $stable(mode_q[c]));

    // R6: the complete bit only rises after the writer signals the end
    p_done_after_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q[c]) |-> $past(finish[c]));
  end

  assign ctrl_word = {22'd0, done_q[1], done_q[0], 4'd0, mode_q[1], mode_q[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rvalid  <= 1'b0;
      r_buf_q     <= 1'b0;
      r_ch_q      <= 1'b0;
      r_ctrl_q    <= 1'b0;
      ctrl_snap_q <= '0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) begin
        r_buf_q     <= buf_sel;
        r_ch_q      <= reg_addr[ADDR_W-2];
        r_ctrl_q    <= ctrl_sel;
        ctrl_snap_q <= ctrl_word;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rvalid) begin
      if (r_buf_q)       reg_rdata = ram_q[r_ch_q];
      else if (r_ctrl_q) reg_rdata = ctrl_snap_q;
    end
  end

  assign irq = |done_q;

  // R9: read data valid is a one-cycle echo of the read strobe
  p_rvalid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);
endmodule

// File: tb/test_adc_pair_capture.sv
module test_adc_pair_capture;
  localparam int BL = 5;
  localparam int SH = 2;
  localparam int AWD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AWD-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic reg_rvalid, irq;
  logic [1:0] cnv, sck;
  logic [1:0] busy = 2'b00, sdo;

  int vectors = 0, miscompares = 0;

  always #2.5 clk = ~clk;

  adc_pair_capture #(.BURST_LEN(BL), .SCK_HALF(SH)) i_adc_pair_capture (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .adc_cnv(cnv), .adc_sck(sck),
    .adc_busy(busy), .adc_sdo(sdo), .irq(irq));

  function automatic logic [15:0] sval(input logic [15:0] seed, input int k);
    return seed ^ 16'(k * 16'h2B4D + k);
  endfunction

  // converter models
  logic [15:0] seed [2];
  logic [15:0] cur [2];
  int idx [2], convs [2], rises [2], bcnt [2];
  int cnv_long = 0;
  logic [1:0] sck_d = 2'b00, cnv_d = 2'b00;

  initial begin
    for (int c = 0; c < 2; c++) begin
      cur[c] = '0; idx[c] = 15; convs[c] = 0; rises[c] = 0; bcnt[c] = 0; seed[c] = '0;
    end
  end

  always @(posedge clk) begin
    sck_d <= sck;
    cnv_d <= cnv;
    for (int c = 0; c < 2; c++) begin
      if (cnv[c] && cnv_d[c]) cnv_long <= cnv_long + 1;
      if (cnv[c] && !cnv_d[c]) begin
        cur[c]   <= sval(seed[c], convs[c]);
        convs[c] <= convs[c] + 1;
        idx[c]   <= 15;
        busy[c]  <= 1'b1;
        bcnt[c]  <= 3;
      end else if (bcnt[c] > 0) begin
        bcnt[c] <= bcnt[c] - 1;
        if (bcnt[c] == 1) busy[c] <= 1'b0;
      end
      if (sck[c] && !sck_d[c]) begin
        rises[c] <= rises[c] + 1;
        idx[c]   <= idx[c] - 1;
      end
    end
  end

  always_comb begin
    for (int c = 0; c < 2; c++) sdo[c] = (idx[c] >= 0) ? cur[c][idx[c][3:0]] : 1'b0;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AWD-1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AWD-1:0] a, output logic [31:0] d, output logic v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata; v = reg_rvalid;
  endtask

  task automatic wait_done(input int ch);
    logic [31:0] d; logic v;
    for (int i = 0; i < 400; i++) begin
      rd(0, d, v);
      if (d[8+ch]) break;
    end
  endtask

  task automatic check_buf(input int ch, input int n, input int base, input string req);
    logic [31:0] d, e; logic v;
    for (int w = 0; w < (n + 1) / 2; w++) begin
      rd(AWD'(8 + 4 * ch + w), d, v);
      e[15:0]  = sval(seed[ch], base + 2 * w);
      e[31:16] = (2 * w + 1 < n) ? sval(seed[ch], base + 2 * w + 1) : 16'h0;
      check(req, d, e);
    end
  endtask

  // vector table: {channel, mode, seed}
  localparam logic [18:0] VEC [6] = '{
    {1'b0, 2'd1, 16'hA5C3},
    {1'b1, 2'd1, 16'h1234},
    {1'b0, 2'd2, 16'h0F0F},
    {1'b1, 2'd3, 16'hFFFF},
    {1'b0, 2'd1, 16'h8001},
    {1'b1, 2'd2, 16'h0000}
  };

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] d; logic v;
    int base, r0, base0, base1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 cnv/sck", {28'd0, cnv, sck}, 32'd0);
    check("R1 rvalid", {31'd0, reg_rvalid}, 32'd0);
    rst_n = 1'b1;
    rd(0, d, v);
    check("R1 ctrl", d, 32'd0);
    check("R9 rvalid", {31'd0, v}, 32'd1);

    for (int i = 0; i < 6; i++) begin
      int ch, md, n;
      ch = int'(VEC[i][18]); md = int'(VEC[i][17:16]);
      n  = md[1] ? BL : 1;
      seed[ch] = VEC[i][15:0];
      base = convs[ch]; r0 = rises[ch];
      wr(0, 32'h300 | (32'(md) << (2 * ch)));
      wait_done(ch);
      check("R6 irq set", {31'd0, irq}, 32'd1);
      rd(0, d, v);
      check("R3 ctrl readback", d & (32'h100 << ch | 32'h3 << (2 * ch)),
            (32'h100 << ch) | (32'(md) << (2 * ch)));
      check("R2 sck edges", 32'(rises[ch] - r0), 32'(16 * n));
      check(md[1] ? "R5 burst data" : "R4 single data", 32'(convs[ch] - base), 32'(n));
      check_buf(ch, n, base, md[1] ? "R5 burst words" : "R4 single word");
      wr(0, 32'h300 & ~(32'h100 << ch));
      rd(0, d, v);
      check("R7 done cleared", {31'd0, d[8+ch]}, 32'd0);
      check("R6 irq clear", {31'd0, irq}, 32'd0);
    end

    // R7: writing ones to complete bits does not set them
    wr(0, 32'h300);
    rd(0, d, v);
    check("R7 no set", d, 32'd0);
    check("R7 irq", {31'd0, irq}, 32'd0);

    // R8: mode write during a burst is ignored
    seed[0] = 16'h3C3C; base = convs[0]; r0 = rises[0];
    wr(0, 32'h302);
    wr(0, 32'h301);
    rd(0, d, v);
    check("R8 mode kept", {30'd0, d[1:0]}, 32'd2);
    wait_done(0);
    repeat (200) @(negedge clk);
    check("R8 conv count", 32'(convs[0] - base), 32'(BL));
    check("R8 edges", 32'(rises[0] - r0), 32'(16 * BL));
    check_buf(0, BL, base, "R8 data");
    wr(0, 32'h000);

    // R10: both channels concurrently; R6 irq held by either
    seed[0] = 16'h7777; seed[1] = 16'hC0DE;
    base0 = convs[0]; base1 = convs[1];
    wr(0, 32'h309);
    repeat (1500) @(negedge clk);
    rd(0, d, v);
    check("R10 both done", d, 32'h0000_0309);
    check_buf(0, 1, base0, "R10 ch0 data");
    check_buf(1, BL, base1, "R10 ch1 data");
    wr(0, 32'h200);
    check("R6 irq one left", {31'd0, irq}, 32'd1);
    wr(0, 32'h000);
    check("R6 irq none", {31'd0, irq}, 32'd0);

    // R9: unmapped address reads zero
    rd(AWD'(1), d, v);
    check("R9 unmapped", d, 32'd0);
    check("R9 valid", {31'd0, v}, 32'd1);
    @(negedge clk);
    check("R9 valid pulse", {31'd0, reg_rvalid}, 32'd0);

    // R2: convert strobe never longer than one clock
    check("R2 cnv width", 32'(cnv_long), 32'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule